// File: doc/BRIEF.md
# Configuration Write Protection Guard

This block sits between a configuration write port and a bank of twelve protected configuration registers. Each protected register owns one protection bit. While that bit is set, the register's write request is blocked, so the register keeps its value. Software can set and clear protection bits as often as it likes. It can also seal any of them: a sealed protection bit keeps its current value until the next reset.

Protection state lives in two small registers, both reachable through the block's own write port: a lock register and a commit register. Bit i of each belongs to protected register i. Data bit 12 of a write is an "every register" selector, which applies the write to all twelve slots at once. The protected registers themselves lie outside the block. It only turns their raw write requests into filtered write enables, and it shows the lock and commit state on output ports so that it can be read back.

Top module: `reg_lock_guard`

## Requirements
- R1: After reset, every lock bit and every commit bit is 0, and every write request passes through unchanged.
- R2: A write with the strobe high and the address equal to LOCK_ADDR (default 2) loads data bit i into lock bit i for every slot whose commit bit is 0. The new value is visible on lockState after the next rising clock edge.
- R3: regWrEn[i] equals regWrReq[i] when lock bit i is 0, and it is 0 whenever lock bit i is 1. Protection bit i guards protected register i, for i from 0 to 11.
- R4: Writing 0 to an uncommitted lock bit unlocks its register, so later requests for that register pass again.
- R5: A write to COMMIT_ADDR (default 3) sets every commit bit whose data bit is 1. A data bit of 0 leaves the commit bit unchanged, so commit bits can only be cleared by reset.
- R6: Once commit bit i is 1, no lock write changes lock bit i, and it holds its value until reset.
- R7: When data bit 12 is 1, a lock write sets every uncommitted lock bit to 1 and a commit write sets all twelve commit bits, regardless of data bits 11 to 0.
- R8: A write with the strobe low, or a write to any other address, changes neither lockState nor commitState.
- R9: A lock change takes effect on the first cycle after the write edge. A request made in the same cycle as the lock write is still filtered by the old lock value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the lock and commit registers |
| cfgAddr | input | ADDR_W (4) | Write address |
| cfgWrData | input | NUM_REGS+1 (13) | Write data: bits 11..0 select slots, bit 12 selects all slots |
| regWrReq | input | NUM_REGS (12) | Raw write requests, one per protected register |
| regWrEn | output | NUM_REGS (12) | Filtered write enables, one per protected register |
| lockState | output | NUM_REGS (12) | Current lock bits |
| commitState | output | NUM_REGS (12) | Current commit bits |

## Verification
The bound checker checks four things on every cycle. First, no enable is ever raised for a locked register, and none is raised without a request. Second, commit bits never fall, and a committed lock bit never moves. Third, an idle or misaddressed write port leaves both state registers still. Fourth, a lock write lands exactly on the uncommitted bits, including the effect of the all-slots selector. Some behaviour can only be shown by the bench's scenarios: the same-cycle ordering between a lock write and a request, the values after reset, the lock, unlock and relock cycles, and the way all the rules combine over long random mixes of operations.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;

  // Decoded write strobes handed from the control decoder to the state datapath.
  typedef struct packed {
    logic lockWr;    // write aimed at the lock register
    logic commitWr;  // write aimed at the commit register
    logic allSel;    // every-slot selector bit of the write data
  } guardStrobes_t;

  // Slot positions of the protected registers; bit i of lock/commit guards slot i.
  localparam int unsigned SLOT_RUN_CTL     = 0;
  localparam int unsigned SLOT_CTL_A       = 1;
  localparam int unsigned SLOT_CTL_B       = 2;
  localparam int unsigned SLOT_BASE_ADDR   = 3;
  localparam int unsigned SLOT_CRC_SEED    = 4;
  localparam int unsigned SLOT_REF_VALUE   = 5;
  localparam int unsigned SLOT_WDOG_CFG    = 6;
  localparam int unsigned SLOT_WDOG_LO     = 7;
  localparam int unsigned SLOT_WDOG_HI     = 8;
  localparam int unsigned SLOT_ALARM_FORCE = 9;
  localparam int unsigned SLOT_IRQ_MASK    = 10;
  localparam int unsigned SLOT_IRQ_FORCE   = 11;

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import reg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned LOCK_ADDR   = 2,
  parameter int unsigned COMMIT_ADDR = 3
) (
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              allBit,
  output guardStrobes_t     strobes
);

  localparam logic [ADDR_W-1:0] LockAddrV   = ADDR_W'(LOCK_ADDR);
  localparam logic [ADDR_W-1:0] CommitAddrV = ADDR_W'(COMMIT_ADDR);

  always_comb begin
    strobes.lockWr   = cfgWrEn && (cfgAddr == LockAddrV);
    strobes.commitWr = cfgWrEn && (cfgAddr == CommitAddrV);
    strobes.allSel   = allBit;
  end

endmodule

// File: rtl/guard_state.sv
module guard_state
  import reg_guard_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  guardStrobes_t       strobes,
  input  logic [NUM_REGS-1:0] selBits,
  output logic [NUM_REGS-1:0] lockQ,
  output logic [NUM_REGS-1:0] commitQ
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : gSlot
    logic lockBit;
    logic commitBit;
    logic slotSel;

    assign slotSel = selBits[i] || strobes.allSel;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lockBit   <= 1'b0;
        commitBit <= 1'b0;
      end else begin
        // commit is set-only
        if (strobes.commitWr && slotSel) commitBit <= 1'b1;
        // lock follows the write data unless sealed
        if (strobes.lockWr && !commitBit) lockBit <= slotSel;
      end
    end

    assign lockQ[i]   = lockBit;
    assign commitQ[i] = commitBit;
  end

endmodule

// File: rtl/guard_filter.sv
module guard_filter #(
  parameter int unsigned NUM_REGS = 12
) (
  input  logic [NUM_REGS-1:0] regWrReq,
  input  logic [NUM_REGS-1:0] lockQ,
  output logic [NUM_REGS-1:0] regWrEn
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : gGate
    assign regWrEn[i] = regWrReq[i] && !lockQ[i];
  end

endmodule

// File: rtl/reg_lock_guard.sv
module reg_lock_guard
  import reg_guard_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 12,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned LOCK_ADDR   = 2,
  parameter int unsigned COMMIT_ADDR = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [NUM_REGS:0]   cfgWrData,
  input  logic [NUM_REGS-1:0] regWrReq,
  output logic [NUM_REGS-1:0] regWrEn,
  output logic [NUM_REGS-1:0] lockState,
  output logic [NUM_REGS-1:0] commitState
);

  localparam int unsigned AllBitPos = NUM_REGS;

  guardStrobes_t       strobes;
  logic [NUM_REGS-1:0] lockQ;
  logic [NUM_REGS-1:0] commitQ;

  guard_ctrl #(
    .ADDR_W     (ADDR_W),
    .LOCK_ADDR  (LOCK_ADDR),
    .COMMIT_ADDR(COMMIT_ADDR)
  ) ctrlInst (
    .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr),
    .allBit (cfgWrData[AllBitPos]),
    .strobes(strobes)
  );

  guard_state #(
    .NUM_REGS(NUM_REGS)
  ) stateInst (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .selBits(cfgWrData[NUM_REGS-1:0]),
    .lockQ  (lockQ),
    .commitQ(commitQ)
  );

  guard_filter #(
    .NUM_REGS(NUM_REGS)
  ) filterInst (
    .regWrReq(regWrReq),
    .lockQ   (lockQ),
    .regWrEn (regWrEn)
  );

  assign lockState   = lockQ;
  assign commitState = commitQ;

endmodule

// File: rtl/reg_lock_guard_chk.sv
module reg_lock_guard_chk #(
  parameter int unsigned NUM_REGS    = 12,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned LOCK_ADDR   = 2,
  parameter int unsigned COMMIT_ADDR = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrEn,
  input logic [ADDR_W-1:0]   cfgAddr,
  input logic [NUM_REGS:0]   cfgWrData,
  input logic [NUM_REGS-1:0] regWrReq,
  input logic [NUM_REGS-1:0] regWrEn,
  input logic [NUM_REGS-1:0] lockState,
  input logic [NUM_REGS-1:0] commitState
);

  logic lockHit;
  logic commitHit;
  assign lockHit   = cfgWrEn && (cfgAddr == ADDR_W'(LOCK_ADDR));
  assign commitHit = cfgWrEn && (cfgAddr == ADDR_W'(COMMIT_ADDR));

  a_r3_locked_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn & lockState) == '0);

  a_r3_no_spurious_enable: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn & ~regWrReq) == '0);

  a_r5_commit_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((commitState & $past(commitState)) == $past(commitState)));

  a_r6_sealed_lock_frozen: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (((lockState ^ $past(lockState)) & $past(commitState)) == '0));

  a_r8_idle_port_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !lockHit && !commitHit) |=> ($stable(lockState) && $stable(commitState)));

  a_r2_lock_load: assert property (@(posedge clk) disable iff (!rstN)
    (lockHit && !cfgWrData[NUM_REGS]) |=>
      (((lockState ^ $past(cfgWrData[NUM_REGS-1:0])) & ~$past(commitState)) == '0));

  a_r7_all_lock: assert property (@(posedge clk) disable iff (!rstN)
    (lockHit && cfgWrData[NUM_REGS]) |=> ((lockState | $past(commitState)) == '1));

  a_r7_all_commit: assert property (@(posedge clk) disable iff (!rstN)
    (commitHit && cfgWrData[NUM_REGS]) |=> (commitState == '1));

endmodule

bind reg_lock_guard reg_lock_guard_chk #(
  .NUM_REGS   (NUM_REGS),
  .ADDR_W     (ADDR_W),
  .LOCK_ADDR  (LOCK_ADDR),
  .COMMIT_ADDR(COMMIT_ADDR)
) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgAddr    (cfgAddr),
  .cfgWrData  (cfgWrData),
  .regWrReq   (regWrReq),
  .regWrEn    (regWrEn),
  .lockState  (lockState),
  .commitState(commitState)
);

// File: tb/reg_lock_guard_test.sv
`timescale 1ns/1ps
module reg_lock_guard_test;

  localparam int N = 12;
  localparam logic [3:0] LA = 4'h2;
  localparam logic [3:0] CA = 4'h3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [3:0]    cfgAddr = '0;
  logic [N:0]    cfgWrData = '0;
  logic [N-1:0]  regWrReq = '0;
  logic [N-1:0]  regWrEn;
  logic [N-1:0]  lockState;
  logic [N-1:0]  commitState;

  logic [N-1:0]  mLock = '0;
  logic [N-1:0]  mCommit = '0;
  int            nChecks = 0;
  int            nFail = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  reg_lock_guard uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .regWrReq(regWrReq), .regWrEn(regWrEn),
    .lockState(lockState), .commitState(commitState)
  );

  function automatic logic [N-1:0] nextLock(logic [N-1:0] l, logic [N-1:0] c,
                                             logic we, logic [3:0] a, logic [N:0] d);
    if (we && a == LA)
      for (int i = 0; i < N; i++) if (!c[i]) l[i] = d[i] | d[N];
    return l;
  endfunction

  function automatic logic [N-1:0] nextCommit(logic [N-1:0] c, logic we,
                                               logic [3:0] a, logic [N:0] d);
    if (we && a == CA) c = c | d[N-1:0] | {N{d[N]}};
    return c;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; one full cycle of stimulus and checking.
  task automatic step(input logic we, input logic [3:0] a, input logic [N:0] d,
                      input logic [N-1:0] req, input string tag);
    logic [N-1:0] nl, nc;
    cfgWrEn = we; cfgAddr = a; cfgWrData = d; regWrReq = req;
    #1;
    check({tag, " R3 R9 enable"}, regWrEn, req & ~mLock);
    nl = nextLock(mLock, mCommit, we, a, d);
    nc = nextCommit(mCommit, we, a, d);
    @(posedge clk);
    mLock = nl; mCommit = nc;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check({tag, " lock"}, lockState, mLock);
    check({tag, " commit"}, commitState, mCommit);
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWrEn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mLock = '0; mCommit = '0;
    regWrReq = '1;
    #1;
    check("R1 reset lock", lockState, '0);
    check("R1 reset commit", commitState, '0);
    check("R1 reset pass", regWrEn, '1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();

    step(1, LA, 13'h005, '1, "R2 lock 005");
    step(1, LA, 13'h000, '1, "R9 R4 same-cycle unlock");
    step(0, LA, 13'h000, '1, "R4 unlocked pass");
    step(1, LA, 13'h0F0, 12'hA5A, "R2 lock 0F0");
    step(1, CA, 13'h030, '1, "R5 commit 030");
    step(1, CA, 13'h000, '1, "R5 zero commit no effect");
    step(1, LA, 13'h000, '1, "R6 sealed stays locked");
    step(1, LA, 13'hFFF, '1, "R2 lock all low bits");
    step(1, LA, 13'h000, '1, "R6 R4 partial unlock");
    step(1, 4'h5, 13'h1FFF, '1, "R8 other address");
    step(0, LA, 13'h1FFF, '1, "R8 strobe low");
    step(0, CA, 13'h1FFF, '1, "R8 strobe low commit");
    step(1, LA, 13'h1000, '1, "R7 all-slot lock");
    step(1, LA, 13'h000, '1, "R4 unlock uncommitted");
    step(1, CA, 13'h1000, '1, "R7 all-slot commit");
    step(1, LA, 13'h1FFF, '1, "R6 everything sealed");
    doReset();

    for (int round = 0; round < 4; round++) begin
      for (int k = 0; k < 100; k++) begin
        int unsigned r;
        logic [N:0] d;
        logic [3:0] a;
        logic [N-1:0] req;
        r = $urandom % 100;
        req = N'($urandom);
        if (r < 45) begin
          d = {($urandom % 8 == 0) ? 1'b1 : 1'b0, N'($urandom)};
          step(1, LA, d, req, "R2 R7 random lock");
        end else if (r < 49) begin
          d = 13'(14'd1 << ($urandom % 14));
          step(1, CA, d, req, "R5 R6 random commit");
        end else if (r < 75) begin
          a = 4'($urandom);
          if (a == LA || a == CA) a = 4'h7;
          step(1, a, 13'($urandom), req, "R8 random other addr");
        end else begin
          step(0, ($urandom % 2) ? LA : CA, 13'($urandom), req, "R8 random idle");
        end
      end
      doReset();
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule